// File: doc/BRIEF.md
# Masked Multi-Region Receiver Reset Sequencer

This block sequences the reset of a serial receiver that is split into nine reset regions. Six regions sit on the analog side: clock generation, frequency recovery, phase recovery, equalizer, DSP and adaptation. Three regions sit on the coding-layer side: elastic buffer, FEC and PCS. A global reset request starts a run. The run begins when the request is seen high and then seen low. Two mask inputs choose which regions take part. A mode input picks the run style. In sequential mode the selected regions are reset one at a time in a fixed order. In single mode they are all reset together.

The coding-layer regions depend on clocks that the user must report stable. For this reason no coding-layer region is entered, and completion is not signalled, while the user-ready input is low. The sequencer waits in place until that input goes high. Each region is held in reset for a fixed number of cycles. After release, the sequencer waits a fixed settle time before it moves on; this settle time stands in for the region reporting ready. In single mode the user can also pulse any region directly, outside the sequence. There is no data stream here, so every pin is a plain control or status level. The sequencer applies no back-pressure.

Top module: `rx_reset_seq`

## Requirements
- R1: While `rst_n` is low, `region_rst` is all zeros and `rst_done` is low.
- R2: In sequential mode (`seq_mode`=1), at most one region reset is high at a time. Regions are visited in bit order: bit 0 clock generation, 1 frequency recovery, 2 phase recovery, 3 equalizer, 4 DSP, 5 adaptation, 6 buffer, 7 FEC, 8 PCS. Each selected region is driven for HOLD_CYC cycles and is followed by SETTLE_CYC cycles with no region driven. The next selected region starts in the cycle right after that.
- R3: `pma_mask[i]` selects region bit i (for i = 0..5), and `pcs_mask[j]` selects region bit 6+j. A deselected region is never driven by the sequence and takes no cycles.
- R4: In single mode (`seq_mode`=0), all selected regions rise in the same cycle. They are held for HOLD_CYC cycles and then settle for SETTLE_CYC cycles.
- R5: In single mode, `region_rst[i]` is also high in the cycle after `dir_rst[i]` is sampled high. In sequential mode, `dir_rst` has no effect on `region_rst`.
- R6: No region bit 6..8 rises, and `rst_done` does not rise, in a cycle where `user_rdy` was low at the edge before. The sequencer waits and continues in the cycle after `user_rdy` is sampled high.
- R7: `rst_done` is low for the whole run. It rises in the cycle right after the last settle cycle and stays high until the next reset request.
- R8: If `rx_rst` is sampled high, the next cycle has `rst_done` low and no region driven by the sequence, even if a run is in progress. The run restarts from the first selected region after the release.
- R9: With both masks all zero, `rst_done` is high in the first cycle after the release edge, provided `user_rdy` is high.
- R10: A run starts on the first clock edge where `rx_rst` is sampled low after being sampled high. The mode and masks are taken at that edge, and the first selected region is driven in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rst | input | 1 | Global reset request; a run starts on its release |
| seq_mode | input | 1 | 1 = sequential, 0 = single |
| pma_mask | input | NUM_PMA | Selects analog-side regions (bits 0..5) |
| pcs_mask | input | NUM_PCS | Selects coding-layer regions (bits 6..8) |
| user_rdy | input | 1 | User clocks stable; gates coding-layer regions and completion |
| dir_rst | input | NUM_PMA+NUM_PCS | Direct per-region reset, used only in single mode |
| region_rst | output | NUM_PMA+NUM_PCS | Registered per-region reset drives |
| rst_done | output | 1 | Registered completion flag |

## Verification
The assertions check several properties on every cycle:
- sequential mode never drives two regions at once;
- a deselected region is never driven;
- no coding-layer region and no completion rises unless user-ready was high;
- completion never coincides with an active region drive;
- a request always clears both outputs by the next cycle;
- direct resets never leak into the output in sequential mode.

Only the bench's scenarios can show the things that span a whole run. These include the exact visiting order and spacing, the equal start of all regions in single mode, the resume point after a user-ready stall, the restart from the first region after an abort, and the one-cycle completion with empty masks.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_HOLD,
    ST_SETTLE,
    ST_WAITU,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/rxrst_pick.sv
// Finds the lowest enabled region at or above a start position.
module rxrst_pick #(
  parameter int NREG = 9,
  parameter int PW   = 4
) (
  input  logic [NREG-1:0] en,
  input  logic [PW-1:0]   from,
  output logic            found,
  output logic [PW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (en[i] && (i >= int'(from))) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/rxrst_dwell.sv
// Down-counter shared by the hold and settle phases.
module rxrst_dwell #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2
  dwell_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(val)));
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rxrst_pkg::*;
#(
  parameter int NUM_PMA    = 6,
  parameter int NUM_PCS    = 3,
  parameter int HOLD_CYC   = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_rst,
  input  logic                       seq_mode,
  input  logic [NUM_PMA-1:0]         pma_mask,
  input  logic [NUM_PCS-1:0]         pcs_mask,
  input  logic                       user_rdy,
  input  logic [NUM_PMA+NUM_PCS-1:0] dir_rst,
  output logic [NUM_PMA+NUM_PCS-1:0] region_rst,
  output logic                       rst_done
);
  localparam int NREG = NUM_PMA + NUM_PCS;
  localparam int PW   = $clog2(NREG + 1);
  localparam int CMAX = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  seq_st_e         st_q, st_d;
  logic [PW-1:0]   pos_q, pos_d;
  logic [NREG-1:0] en_q, en_d, drv_q, drv_d;
  logic            seqm_q, seqm_d, done_d;

  logic            at_arm, mode_use;
  logic [NREG-1:0] en_use;
  logic            pk_found;
  logic [PW-1:0]   pk_idx;
  logic            step_ok, step_gate, need_gate, do_adv;
  logic [NREG-1:0] step_vec;
  logic [PW-1:0]   step_pos;
  logic            ld, cnt_zero;
  logic [CW-1:0]   ldval;

  // The start edge uses the live mode and masks; later steps use the latched copy.
  assign at_arm   = (st_q == ST_ARM);
  assign en_use   = at_arm ? {pcs_mask, pma_mask} : en_q;
  assign mode_use = at_arm ? seq_mode : seqm_q;

  rxrst_pick #(.NREG(NREG), .PW(PW)) u_pick (
    .en(en_use), .from(pos_q), .found(pk_found), .idx(pk_idx)
  );

  rxrst_dwell #(.CW(CW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .load(ld), .val(ldval), .zero(cnt_zero)
  );

  // The next step: one region in sequential mode, the whole set in single mode.
  always_comb begin
    if (mode_use) begin
      step_ok   = pk_found;
      step_vec  = NREG'(1) << pk_idx;
      step_pos  = pk_idx + 1'b1;
      step_gate = (pk_idx >= PW'(NUM_PMA));
    end else begin
      step_ok   = (pos_q == '0) && (|en_use);
      step_vec  = en_use;
      step_pos  = PW'(NREG);
      step_gate = |en_use[NREG-1:NUM_PMA];
    end
    // Completion is gated like a coding-layer step.
    need_gate = step_ok ? step_gate : 1'b1;
  end

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    en_d   = en_q;
    seqm_d = seqm_q;
    drv_d  = drv_q;
    done_d = rst_done;
    ld     = 1'b0;
    ldval  = '0;
    do_adv = 1'b0;
    if (rx_rst) begin
      st_d   = ST_ARM;
      drv_d  = '0;
      done_d = 1'b0;
      pos_d  = '0;
    end else begin
      unique case (st_q)
        ST_ARM: begin
          en_d   = {pcs_mask, pma_mask};
          seqm_d = seq_mode;
          do_adv = 1'b1;
        end
        ST_WAITU: do_adv = 1'b1;
        ST_HOLD: if (cnt_zero) begin
          st_d  = ST_SETTLE;
          drv_d = '0;
          ld    = 1'b1;
          ldval = CW'(SETTLE_CYC - 1);
        end
        ST_SETTLE: if (cnt_zero) do_adv = 1'b1;
        default: ;
      endcase
      if (do_adv) begin
        if (need_gate && !user_rdy) begin
          st_d  = ST_WAITU;
          drv_d = '0;
        end else if (step_ok) begin
          st_d  = ST_HOLD;
          drv_d = step_vec;
          pos_d = step_pos;
          ld    = 1'b1;
          ldval = CW'(HOLD_CYC - 1);
        end else begin
          st_d   = ST_DONE;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pos_q      <= '0;
      en_q       <= '0;
      seqm_q     <= 1'b1;
      drv_q      <= '0;
      rst_done   <= 1'b0;
      region_rst <= '0;
    end else begin
      st_q       <= st_d;
      pos_q      <= pos_d;
      en_q       <= en_d;
      seqm_q     <= seqm_d;
      drv_q      <= drv_d;
      rst_done   <= done_d;
      region_rst <= drv_d | (seq_mode ? '0 : dir_rst);
    end
  end

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> (drv_q == '0));
  // R2
  seq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seqm_q |-> $onehot0(drv_q));
  // R6
  pcs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|drv_q[NREG-1:NUM_PMA]) |-> $past(user_rdy));
  // R6
  done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_done) |-> $past(user_rdy));
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (!rst_done && (drv_q == '0)));
  // R3
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q & ~en_q) == '0);
  // R5
  seq_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_mode) |-> (region_rst == drv_q));
endmodule

// File: tb/sim_rx_reset_seq.sv
module sim_rx_reset_seq;
  localparam int H = 4;
  localparam int S = 3;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_rst = 1'b0;
  logic seq_mode = 1'b1;
  logic [5:0] pma_mask = '1;
  logic [2:0] pcs_mask = '1;
  logic user_rdy = 1'b1;
  logic [N-1:0] dir_rst = '0;
  logic [N-1:0] region_rst;
  logic rst_done;

  int nchk = 0, nfail = 0, cyc = 0;
  int rise[N];
  int done_rise = -1;
  logic [N-1:0] prev_out = '0;
  logic prev_done = 1'b0;

  // Reference model state
  int m_st = 0;            // 0 idle 1 armed 2 hold 3 settle 4 wait 5 done
  int m_left = 0;
  int qvec[$];
  bit qgate[$];
  logic [N-1:0] m_vec = '0;
  logic m_done = 1'b0;
  logic [N-1:0] m_out = '0;

  always #5 clk = ~clk;

  rx_reset_seq #(.NUM_PMA(6), .NUM_PCS(3), .HOLD_CYC(H), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .seq_mode(seq_mode),
    .pma_mask(pma_mask), .pcs_mask(pcs_mask), .user_rdy(user_rdy),
    .dir_rst(dir_rst), .region_rst(region_rst), .rst_done(rst_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic m_advance();
    if (qvec.size() == 0) begin
      if (user_rdy) begin m_st = 5; m_done = 1'b1; end
      else m_st = 4;
    end else if (qgate[0] && !user_rdy) begin
      m_st = 4; m_vec = '0;
    end else begin
      m_vec = N'(qvec.pop_front());
      void'(qgate.pop_front());
      m_st = 2; m_left = H;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_vec = '0; m_done = 1'b0; qvec.delete(); qgate.delete();
    end else if (rx_rst) begin
      m_st = 1; m_vec = '0; m_done = 1'b0; qvec.delete(); qgate.delete();
    end else begin
      case (m_st)
        1: begin
          logic [N-1:0] en;
          en = {pcs_mask, pma_mask};
          if (seq_mode) begin
            for (int i = 0; i < N; i++)
              if (en[i]) begin qvec.push_back(1 << i); qgate.push_back(i >= 6); end
          end else if (en != '0) begin
            qvec.push_back(int'(en)); qgate.push_back(|en[8:6]);
          end
          m_advance();
        end
        2: begin m_left--; if (m_left == 0) begin m_st = 3; m_vec = '0; m_left = S; end end
        3: begin m_left--; if (m_left == 0) m_advance(); end
        4: m_advance();
        default: ;
      endcase
    end
    m_out = rst_n ? (m_vec | (seq_mode ? '0 : dir_rst)) : '0;
    #1;
    chk(region_rst == m_out, "R2 R4 model region_rst", 32'(region_rst), 32'(m_out));
    chk(rst_done == m_done, "R7 model rst_done", 32'(rst_done), 32'(m_done));
    for (int i = 0; i < N; i++)
      if (region_rst[i] && !prev_out[i] && rise[i] < 0) rise[i] = cyc;
    if (rst_done && !prev_done) done_rise = cyc;
    prev_out = region_rst;
    prev_done = rst_done;
  end

  task automatic clear_log();
    for (int i = 0; i < N; i++) rise[i] = -1;
    done_rise = -1;
  endtask

  // Pulse the request; returns the cycle number of the release edge.
  task automatic trigger(output int rel);
    @(negedge clk) rx_rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(region_rst == '0 || !seq_mode, "R8 drive cleared during request", 32'(region_rst), 0);
    chk(rst_done == 1'b0, "R8 done low during request", 32'(rst_done), 0);
    clear_log();
    rx_rst = 1'b0;
    @(posedge clk);
    #2;
    rel = cyc;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && !rst_done; k++) @(negedge clk);
  endtask

  initial begin
    int rel;
    int ur;
    bit ok;
    clear_log();
    repeat (3) @(negedge clk);
    chk(region_rst == '0, "R1 reset region_rst", 32'(region_rst), 0);
    chk(rst_done == 1'b0, "R1 reset rst_done", 32'(rst_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R10 sequential, all regions
    trigger(rel);
    wait_done();
    ok = 1;
    for (int i = 0; i < N; i++) if (rise[i] != rel + i * (H + S)) ok = 0;
    chk(ok, "R2 R10 order and spacing", 32'(rise[8]), 32'(rel + 8 * (H + S)));
    chk(done_rise == rel + N * (H + S), "R7 done timing", 32'(done_rise), 32'(rel + N * (H + S)));

    // R3 partial masks, skipped regions take no cycles
    pma_mask = 6'b010101; pcs_mask = 3'b101;
    trigger(rel);
    wait_done();
    chk(rise[1] < 0 && rise[3] < 0 && rise[5] < 0 && rise[7] < 0, "R3 masked never driven", 32'(rise[1]), 32'hffffffff);
    chk(rise[2] == rel + (H + S) && rise[8] == rel + 4 * (H + S), "R3 skip without dwell", 32'(rise[8]), 32'(rel + 4 * (H + S)));
    chk(done_rise == rel + 5 * (H + S), "R7 done after partial run", 32'(done_rise), 32'(rel + 5 * (H + S)));

    // R4 single mode, all rise together
    seq_mode = 1'b0; pma_mask = '1; pcs_mask = '1;
    trigger(rel);
    wait_done();
    ok = 1;
    for (int i = 0; i < N; i++) if (rise[i] != rel) ok = 0;
    chk(ok, "R4 simultaneous rise", 32'(rise[8]), 32'(rel));
    chk(done_rise == rel + H + S, "R4 done after single step", 32'(done_rise), 32'(rel + H + S));

    // R5 direct resets in single mode, ignored in sequential mode
    @(negedge clk) dir_rst = 9'h0A5;
    @(negedge clk);
    chk(region_rst == 9'h0A5, "R5 direct reset single mode", 32'(region_rst), 32'h0A5);
    seq_mode = 1'b1;
    @(negedge clk);
    chk(region_rst == '0, "R5 direct ignored sequential", 32'(region_rst), 0);
    dir_rst = '0;

    // R6 user-ready holds off coding-layer regions and completion
    user_rdy = 1'b0;
    trigger(rel);
    repeat (70) @(negedge clk);
    chk(rise[6] < 0 && rise[7] < 0 && rise[8] < 0, "R6 pcs held off", 32'(rise[6]), 32'hffffffff);
    chk(rst_done == 1'b0, "R6 done held off", 32'(rst_done), 0);
    chk(rise[5] == rel + 5 * (H + S), "R6 analog side unaffected", 32'(rise[5]), 32'(rel + 5 * (H + S)));
    user_rdy = 1'b1;
    @(posedge clk);
    #2;
    ur = cyc;
    wait_done();
    chk(rise[6] == ur, "R6 resume right after user_rdy", 32'(rise[6]), 32'(ur));
    chk(done_rise == ur + 3 * (H + S), "R6 done after resume", 32'(done_rise), 32'(ur + 3 * (H + S)));

    // R8 abort mid-run and restart from first region
    trigger(rel);
    repeat (12) @(negedge clk);
    trigger(rel);
    chk(rise[0] == rel, "R8 restart from first region", 32'(rise[0]), 32'(rel));
    wait_done();
    chk(done_rise == rel + N * (H + S), "R8 done after restart", 32'(done_rise), 32'(rel + N * (H + S)));

    // R9 empty masks
    pma_mask = '0; pcs_mask = '0;
    trigger(rel);
    @(negedge clk);
    chk(done_rise == rel, "R9 empty masks done next cycle", 32'(done_rise), 32'(rel));

    // R9 R6 empty masks still wait for user-ready
    user_rdy = 1'b0;
    trigger(rel);
    repeat (5) @(negedge clk);
    chk(rst_done == 1'b0, "R9 empty waits for user_rdy", 32'(rst_done), 0);
    user_rdy = 1'b1;
    @(posedge clk);
    #2;
    chk(rst_done == 1'b1, "R9 done once user_rdy high", 32'(rst_done), 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1_500_000;
    nfail++;
    nchk++;
    $display("FAIL R7 watchdog: run did not finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule